// File: doc/BRIEF.md
# Digital Potentiometer Two-Wire Command Slave

This block is the serial front end of a four-channel digital potentiometer. It watches a two-wire bus (clock and open-drain data), detects START and STOP, accepts an address byte whose upper nibble is a fixed device type and whose lower nibble must equal four strap pins, and then decodes an instruction byte. It returns the instruction's opcode, register index and channel index on a command port that a neighbouring register bank decodes.

An instruction frame takes one of three forms. Transfer instructions end after the instruction byte. Write instructions carry a third byte holding a six-bit value. Read instructions make the slave return a six-bit value, which it takes from the register bank. A step instruction puts the frame into a mode where every further bus clock pulse moves the selected wiper one position, up or down according to the data line. While the register bank reports a nonvolatile write in progress, the slave withholds its address acknowledge so the host can poll until the write completes.

Both bus lines are sampled by the system clock through synchronizers. A transfer or write command is issued as a single-cycle pulse at the STOP that closes a complete frame, so an aborted frame never reaches the register bank.

Top module: `dpot_bus_slave`

## Requirements
- R1: During and after reset the data line is released (`sda_low_o`=0) and no command is issued.
- R2: The slave takes part only in frames opened by START (data falling while the clock is high). Bytes clocked without a START are not acknowledged. STOP (data rising while the clock is high) releases the data line.
- R3: The address byte is sent MSB first. Its bits 7:4 must be 0101 and its bits 3:0 must equal `dev_addr_i`. On any mismatch the ninth clock gets no acknowledge, and no command follows until the next START.
- R4: While `nv_busy_i` is high, an address byte that would otherwise match gets no acknowledge. Once `nv_busy_i` is low, the same address is acknowledged again.
- R5: The instruction byte is sent MSB first. Bits 7:4 are the opcode, bits 3:2 the register index and bits 1:0 the channel index. The valid opcodes are 1001, 1010, 1011, 1100, 1101, 1110, 0001, 1000 and 0010. Any other opcode is not acknowledged and issues nothing.
- R6: The transfer opcodes (1101, 1110, 0001, 1000) are acknowledged and issue one command at the STOP that follows. The command is a one-cycle `cmd_valid_o` pulse carrying the opcode, register index and channel index.
- R7: The write opcodes (1010, 1100) acknowledge a third byte and issue one command at the following STOP. `cmd_data_o` carries bits 5:0 of that byte; bits 7:6 are ignored.
- R8: The read opcodes (1001, 1011) make the slave send `{2'b00, rd_data_i}` MSB first. The slave releases the data line for the master's ninth-clock acknowledge, and a read issues no command.
- R9: After a step opcode (0010) is acknowledged, each clock pulse issues one command with opcode 0010 when the clock falls. `cmd_up_o` is 1 if data was high during the pulse and 0 if it was low. The STOP that ends the frame issues no step.
- R10: A STOP or a repeated START before a frame is complete (the instruction acknowledged for a transfer, the data byte acknowledged for a write) issues no command.
- R11: The slave starts pulling the data line low only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| dev_addr_i | input | 4 | Strap value for the low address nibble |
| nv_busy_i | input | 1 | Nonvolatile write in progress in the register bank |
| rd_data_i | input | DATA_W | Value selected by cmd_op_o/cmd_reg_o/cmd_chan_o, for reads |
| sda_low_o | output | 1 | 1 pulls the data line low (open-drain enable) |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_op_o | output | 4 | Latched opcode |
| cmd_reg_o | output | 2 | Latched register index |
| cmd_chan_o | output | 2 | Latched channel index |
| cmd_data_o | output | DATA_W | Write data from the third byte |
| cmd_up_o | output | 1 | Step direction, 1 is up |

## Verification
A state register that has slipped by one bit shows up at the ports within one byte slot: an acknowledge lands on the wrong ninth clock, or read data arrives shifted by one bit. A wrongly latched opcode class shows up at the end of the frame, as a command that is missing, duplicated or issued without STOP, on the one-cycle strobe that follows STOP. Step-mode faults show up one system cycle after each clock fall, as a count or direction of step strobes that differs from the pulses the master sent.

// File: rtl/dpot_bus_pkg.sv
package dpot_bus_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam logic [NIB_W-1:0] DEV_TYPE = 4'b0101;

  localparam logic [3:0] OP_RD_WIPER      = 4'b1001;
  localparam logic [3:0] OP_WR_WIPER      = 4'b1010;
  localparam logic [3:0] OP_RD_SET        = 4'b1011;
  localparam logic [3:0] OP_WR_SET        = 4'b1100;
  localparam logic [3:0] OP_SET_TO_WIPER  = 4'b1101;
  localparam logic [3:0] OP_WIPER_TO_SET  = 4'b1110;
  localparam logic [3:0] OP_ALL_SET_TO_WP = 4'b0001;
  localparam logic [3:0] OP_ALL_WP_TO_SET = 4'b1000;
  localparam logic [3:0] OP_STEP          = 4'b0010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_INSTR, ST_WDATA, ST_RDATA, ST_STEP, ST_HOLD
  } frame_st_e;

  typedef enum logic [2:0] {
    CLS_BAD, CLS_XFER, CLS_WRITE, CLS_READ, CLS_STEP
  } op_cls_e;

  function automatic op_cls_e op_class(input logic [3:0] op);
    case (op)
      OP_RD_WIPER, OP_RD_SET:                  return CLS_READ;
      OP_WR_WIPER, OP_WR_SET:                  return CLS_WRITE;
      OP_SET_TO_WIPER, OP_WIPER_TO_SET,
      OP_ALL_SET_TO_WP, OP_ALL_WP_TO_SET:      return CLS_XFER;
      OP_STEP:                                 return CLS_STEP;
      default:                                 return CLS_BAD;
    endcase
  endfunction
endpackage

// File: rtl/dpot_bus_sync.sv
module dpot_bus_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/dpot_bus_events.sv
module dpot_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_i;
      sda_p <= sda_i;
    end
  end

  // data edges count as conditions only with the clock steady high
  assign start_o = scl_i & scl_p & sda_p & ~sda_i;
  assign stop_o  = scl_i & scl_p & ~sda_p & sda_i;
  assign rise_o  = scl_i & ~scl_p;
  assign fall_o  = ~scl_i & scl_p;
endmodule

// File: rtl/dpot_bus_slave.sv
module dpot_bus_slave
  import dpot_bus_pkg::*;
#(
  parameter int DATA_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [NIB_W-1:0]  dev_addr_i,
  input  logic              nv_busy_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              sda_low_o,
  output logic              cmd_valid_o,
  output logic [3:0]        cmd_op_o,
  output logic [1:0]        cmd_reg_o,
  output logic [1:0]        cmd_chan_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic              cmd_up_o
);
  localparam int CNT_W = 4;
  localparam int PAD_W = BYTE_W - DATA_W;
  localparam logic [CNT_W-1:0] ACK_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] END_CNT = CNT_W'(BYTE_W + 1);

  logic [1:0] line_raw, line_s;
  logic scl_s, sda_s;
  logic start_evt, stop_evt, scl_rise, scl_fall;

  assign line_raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    dpot_bus_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (line_raw[g]),
      .q_o   (line_s[g])
    );
  end

  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  dpot_bus_events u_events (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_s),
    .sda_i  (sda_s),
    .start_o(start_evt),
    .stop_o (stop_evt),
    .rise_o (scl_rise),
    .fall_o (scl_fall)
  );

  frame_st_e          state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BYTE_W-1:0]  shift_q, tx_q, rd_byte;
  logic               drive_q, pend_q, valid_q, up_q;
  logic [3:0]         op_q;
  logic [1:0]         reg_q, chan_q;
  logic [DATA_W-1:0]  data_q;
  logic               byte_state, addr_ok;
  op_cls_e            shift_cls, held_cls;

  assign byte_state = (state_q == ST_ADDR) || (state_q == ST_INSTR) ||
                      (state_q == ST_WDATA) || (state_q == ST_RDATA);
  assign addr_ok    = (shift_q[BYTE_W-1:NIB_W] == DEV_TYPE) &&
                      (shift_q[NIB_W-1:0] == dev_addr_i) && !nv_busy_i;
  assign shift_cls  = op_class(shift_q[BYTE_W-1:NIB_W]);
  assign held_cls   = op_class(op_q);
  assign rd_byte    = {{PAD_W{1'b0}}, rd_data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      tx_q    <= '0;
      drive_q <= 1'b0;
      pend_q  <= 1'b0;
      valid_q <= 1'b0;
      up_q    <= 1'b0;
      op_q    <= '0;
      reg_q   <= '0;
      chan_q  <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      if (stop_evt) begin
        valid_q <= (state_q == ST_HOLD) && pend_q;
        state_q <= ST_IDLE;
        pend_q  <= 1'b0;
        drive_q <= 1'b0;
        cnt_q   <= '0;
      end else if (start_evt) begin
        state_q <= ST_ADDR;
        pend_q  <= 1'b0;
        drive_q <= 1'b0;
        cnt_q   <= '0;
      end else if (state_q == ST_STEP) begin
        if (scl_fall) begin
          valid_q <= 1'b1;
          up_q    <= sda_s;
        end
      end else if (byte_state) begin
        if (scl_rise) begin
          if (cnt_q < ACK_CNT) shift_q <= {shift_q[BYTE_W-2:0], sda_s};
          cnt_q <= cnt_q + 1'b1;
        end else if (scl_fall) begin
          if (cnt_q == ACK_CNT) begin
            // ninth clock: acknowledge or drop out
            unique case (state_q)
              ST_ADDR: begin
                if (addr_ok) drive_q <= 1'b1;
                else         state_q <= ST_IDLE;
              end
              ST_INSTR: begin
                if (shift_cls != CLS_BAD) begin
                  drive_q <= 1'b1;
                  op_q    <= shift_q[7:4];
                  reg_q   <= shift_q[3:2];
                  chan_q  <= shift_q[1:0];
                end else begin
                  state_q <= ST_IDLE;
                end
              end
              ST_WDATA: begin
                drive_q <= 1'b1;
                data_q  <= shift_q[DATA_W-1:0];
              end
              default: drive_q <= 1'b0;
            endcase
          end else if (cnt_q == END_CNT) begin
            cnt_q   <= '0;
            drive_q <= 1'b0;
            unique case (state_q)
              ST_ADDR:  state_q <= ST_INSTR;
              ST_INSTR: begin
                unique case (held_cls)
                  CLS_STEP:  state_q <= ST_STEP;
                  CLS_WRITE: state_q <= ST_WDATA;
                  CLS_READ: begin
                    state_q <= ST_RDATA;
                    drive_q <= ~rd_byte[BYTE_W-1];
                    tx_q    <= {rd_byte[BYTE_W-2:0], 1'b0};
                  end
                  default: begin
                    state_q <= ST_HOLD;
                    pend_q  <= 1'b1;
                  end
                endcase
              end
              ST_WDATA: begin
                state_q <= ST_HOLD;
                pend_q  <= 1'b1;
              end
              default:  state_q <= ST_HOLD;
            endcase
          end else if (state_q == ST_RDATA && cnt_q != '0) begin
            drive_q <= ~tx_q[BYTE_W-1];
            tx_q    <= {tx_q[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign sda_low_o   = drive_q;
  assign cmd_valid_o = valid_q;
  assign cmd_op_o    = op_q;
  assign cmd_reg_o   = reg_q;
  assign cmd_chan_o  = chan_q;
  assign cmd_data_o  = data_q;
  assign cmd_up_o    = up_q;
endmodule

// File: rtl/dpot_bus_slave_chk.sv
module dpot_bus_slave_chk
  import dpot_bus_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             scl_s,
  input logic             scl_fall,
  input logic             stop_evt,
  input frame_st_e        state_q,
  input logic [3:0]       cnt_q,
  input logic [BYTE_W-1:0] shift_q,
  input logic             nv_busy_i,
  input logic             sda_low_o,
  input logic             cmd_valid_o,
  input logic [3:0]       cmd_op_o
);
  logic ack_fall_addr, ack_fall_instr;
  assign ack_fall_addr  = scl_fall && (state_q == ST_ADDR)  && (cnt_q == 4'd8);
  assign ack_fall_instr = scl_fall && (state_q == ST_INSTR) && (cnt_q == 4'd8);

  assert_strobe_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);

  assert_issue_at_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o != OP_STEP) |-> $past(stop_evt));

  assert_step_on_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_op_o == OP_STEP) |-> $past(scl_fall));

  assert_pull_while_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_low_o) |-> !$past(scl_s));

  assert_busy_nack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fall_addr && nv_busy_i) |=> !sda_low_o);

  assert_type_nack_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fall_addr && shift_q[7:4] != DEV_TYPE) |=> !sda_low_o);

  assert_bad_op_nack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fall_instr && op_class(shift_q[7:4]) == CLS_BAD) |=> !sda_low_o);

  assert_stop_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt |=> !sda_low_o);
endmodule

bind dpot_bus_slave dpot_bus_slave_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_s      (scl_s),
  .scl_fall   (scl_fall),
  .stop_evt   (stop_evt),
  .state_q    (state_q),
  .cnt_q      (cnt_q),
  .shift_q    (shift_q),
  .nv_busy_i  (nv_busy_i),
  .sda_low_o  (sda_low_o),
  .cmd_valid_o(cmd_valid_o),
  .cmd_op_o   (cmd_op_o)
);

// File: tb/dpot_bus_slave_bench.sv
module dpot_bus_slave_bench;
  localparam int Q = 8;
  localparam logic [3:0] PINS = 4'b1011;
  localparam logic [7:0] ADDR = {4'b0101, PINS};

  // {instr, third byte, expected instr ack, expected commands}
  localparam logic [17:0] VEC [9] = '{
    {8'hA1, 8'hEA, 1'b1, 1'b1},
    {8'hCB, 8'h15, 1'b1, 1'b1},
    {8'hD6, 8'h00, 1'b1, 1'b1},
    {8'hEC, 8'h00, 1'b1, 1'b1},
    {8'h18, 8'h00, 1'b1, 1'b1},
    {8'h84, 8'h00, 1'b1, 1'b1},
    {8'h00, 8'h00, 1'b0, 1'b0},
    {8'hF0, 8'h00, 1'b0, 1'b0},
    {8'h30, 8'h00, 1'b0, 1'b0}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, nv_busy = 1'b0;
  logic sda_low, cmd_valid, cmd_up;
  logic [3:0] cmd_op;
  logic [1:0] cmd_reg, cmd_chan;
  logic [5:0] cmd_data, rd_data;
  logic sda_bus;

  logic [5:0] wip [4];
  logic [5:0] setr [16];

  int ntot = 0, npass = 0, ncmd = 0, nup = 0, ndn = 0;
  logic [3:0] last_op;
  logic [1:0] last_reg, last_chan;
  logic [5:0] last_data;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  assign sda_bus = sda_m & ~sda_low;
  assign rd_data = (cmd_op == 4'b1001) ? wip[cmd_chan] : setr[{cmd_chan, cmd_reg}];

  dpot_bus_slave u_dpot_bus_slave (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda_bus),
    .dev_addr_i(PINS), .nv_busy_i(nv_busy), .rd_data_i(rd_data),
    .sda_low_o(sda_low), .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op),
    .cmd_reg_o(cmd_reg), .cmd_chan_o(cmd_chan), .cmd_data_o(cmd_data),
    .cmd_up_o(cmd_up)
  );

  // register bank model fed from the command port
  always @(negedge clk_i) begin
    if (rst_ni && cmd_valid) begin
      ncmd++;
      last_op = cmd_op; last_reg = cmd_reg; last_chan = cmd_chan; last_data = cmd_data;
      case (cmd_op)
        4'b1010: wip[cmd_chan] = cmd_data;
        4'b1100: setr[{cmd_chan, cmd_reg}] = cmd_data;
        4'b1101: wip[cmd_chan] = setr[{cmd_chan, cmd_reg}];
        4'b1110: setr[{cmd_chan, cmd_reg}] = wip[cmd_chan];
        4'b0001: for (int c = 0; c < 4; c++) wip[c] = setr[{c[1:0], cmd_reg}];
        4'b1000: for (int c = 0; c < 4; c++) setr[{c[1:0], cmd_reg}] = wip[c];
        4'b0010: begin
          if (cmd_up) begin nup++; if (wip[cmd_chan] != 6'h3F) wip[cmd_chan] = wip[cmd_chan] + 6'd1; end
          else begin ndn++; if (wip[cmd_chan] != 6'h00) wip[cmd_chan] = wip[cmd_chan] - 6'd1; end
        end
        default: ;
      endcase
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    ntot++;
    if (act == exp) npass++;
    else $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
  endtask

  task automatic half();
    repeat (Q) @(negedge clk_i);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; half(); scl = 1'b1; half(); sda_m = 1'b0; half(); scl = 1'b0; half();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; half(); scl = 1'b1; half(); sda_m = 1'b1; half();
  endtask

  task automatic bus_bit(input logic b, output logic seen);
    sda_m = b; half(); scl = 1'b1; half(); seen = sda_bus; scl = 1'b0; half();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(output logic [7:0] b, output logic released);
    logic s;
    for (int i = 7; i >= 0; i--) begin bus_bit(1'b1, s); b[i] = s; end
    bus_bit(1'b1, s);
    released = s;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      ntot++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", npass, ntot);
      $finish;
    end
  end

  initial begin
    logic ack, rel;
    logic [7:0] rb;
    int base;
    for (int c = 0; c < 4; c++) wip[c] = '0;
    for (int c = 0; c < 16; c++) setr[c] = '0;

    repeat (5) @(negedge clk_i);
    chk("R1 data released in reset", int'(sda_low), 0);
    chk("R1 no command in reset", int'(cmd_valid), 0);
    rst_ni = 1'b1;
    repeat (10) @(negedge clk_i);
    chk("R1 data released after reset", int'(sda_low), 0);
    scl = 1'b0; half();

    // R2: byte with no START
    wr_byte(ADDR, ack);
    chk("R2 no ack without START", int'(ack), 0);
    bus_stop();

    // vector table
    for (int v = 0; v < 9; v++) begin
      base = ncmd;
      bus_start();
      wr_byte(ADDR, ack);
      chk("R3 address ack", int'(ack), 1);
      wr_byte(VEC[v][17:10], ack);
      chk("R5 instruction ack", int'(ack), int'(VEC[v][1]));
      if (ack && (VEC[v][17:14] == 4'b1010 || VEC[v][17:14] == 4'b1100)) begin
        wr_byte(VEC[v][9:2], ack);
        chk("R7 data byte ack", int'(ack), 1);
      end
      bus_stop();
      half();
      chk("R6 R7 command count at STOP", ncmd - base, int'(VEC[v][0]));
      if (VEC[v][0]) begin
        chk("R6 opcode field", int'(last_op), int'(VEC[v][17:14]));
        chk("R6 register field", int'(last_reg), int'(VEC[v][13:12]));
        chk("R6 channel field", int'(last_chan), int'(VEC[v][11:10]));
        if (VEC[v][17:14] == 4'b1010 || VEC[v][17:14] == 4'b1100)
          chk("R7 data low six bits", int'(last_data), int'(VEC[v][7:2]));
      end
    end

    // R3: wrong type and wrong pins
    base = ncmd;
    bus_start(); wr_byte(8'h6B, ack); chk("R3 wrong type nack", int'(ack), 0);
    wr_byte(8'hA1, ack); chk("R3 ignored after mismatch", int'(ack), 0);
    bus_stop();
    bus_start(); wr_byte(8'h5A, ack); chk("R3 wrong pins nack", int'(ack), 0);
    bus_stop(); half();
    chk("R3 no command after mismatch", ncmd - base, 0);

    // R4: busy polling
    nv_busy = 1'b1;
    bus_start(); wr_byte(ADDR, ack); chk("R4 busy nack", int'(ack), 0); bus_stop();
    nv_busy = 1'b0;
    bus_start(); wr_byte(ADDR, ack); chk("R4 ack after busy", int'(ack), 1); bus_stop();

    // R8: reads
    base = ncmd;
    bus_start(); wr_byte(ADDR, ack); wr_byte(8'hBB, ack);
    chk("R8 read instr ack", int'(ack), 1);
    rd_byte(rb, rel);
    chk("R8 setting reg2 ch3 value", int'(rb), 8'h15);
    chk("R8 released on ninth clock", int'(rel), 1);
    bus_stop();
    bus_start(); wr_byte(ADDR, ack); wr_byte(8'h93, ack);
    rd_byte(rb, rel);
    chk("R8 wiper ch3 value", int'(rb), 8'h15);
    bus_stop(); half();
    chk("R8 read issues nothing", ncmd - base, 0);

    // R9: step mode on channel 3
    base = ncmd; nup = 0; ndn = 0;
    bus_start(); wr_byte(ADDR, ack); wr_byte(8'h23, ack);
    chk("R9 step instr ack", int'(ack), 1);
    bus_bit(1'b1, ack); bus_bit(1'b1, ack); bus_bit(1'b0, ack);
    bus_bit(1'b1, ack); bus_bit(1'b1, ack);
    bus_stop(); half();
    chk("R9 one step per pulse, none at STOP", ncmd - base, 5);
    chk("R9 up steps", nup, 4);
    chk("R9 down steps", ndn, 1);
    chk("R9 step channel", int'(last_chan), 3);
    bus_start(); wr_byte(ADDR, ack); wr_byte(8'h93, ack);
    rd_byte(rb, rel);
    chk("R9 wiper ch3 after steps", int'(rb), 8'h18);
    bus_stop();

    // R10: aborted frames
    base = ncmd;
    bus_start(); wr_byte(ADDR, ack); wr_byte(8'hA1, ack); bus_stop();
    half(); chk("R10 STOP before data", ncmd - base, 0);
    bus_start(); wr_byte(ADDR, ack); wr_byte(8'hD6, ack);
    bus_start(); wr_byte(ADDR, ack); bus_stop();
    half(); chk("R10 repeated START after transfer", ncmd - base, 0);
    bus_start(); wr_byte(ADDR, ack); wr_byte(8'hA1, ack);
    for (int i = 0; i < 4; i++) bus_bit(1'b0, ack);
    bus_stop();
    half(); chk("R10 STOP inside data byte", ncmd - base, 0);
    chk("R2 released after STOP", int'(sda_low), 0);

    done = 1;
    $display("%0d/%0d checks passed", npass, ntot);
    $finish;
  end
endmodule